// File: doc/BRIEF.md
# Serial Converter Interface Responder

This block is the device side of the serial port on a sampling converter. The host pulls chip select low and toggles a serial clock. During the frame the block picks up a control byte from the data input. It marks the moment the analog front end stops tracking and starts converting. It then shifts the conversion result out on a data line that can be released to high impedance. All three host signals are brought into an oversampling system clock through synchronisers, and the block finds the serial clock edges in that domain.

Each frame lasts sixteen rising edges of the serial clock. The sample/start strobe fires on the second rising edge. The first eight rising edges fill the control register. The output word is four zero bits followed by the twelve-bit result, most significant bit first. A new output bit appears after each falling edge, so the host can read bit k on rising edge k+1. The channel field written in one frame is moved into a shadow register when that frame completes, so it selects the input for the next frame. If chip select is held low, frames follow one another back to back. A testbench-driven port stands in for the converter core's result.

Top module: `adc_serial_responder`

## Requirements
- R1: After reset, dout_oe_o and track_o are low, ctrl_o is 8'h00 and sample_chan_o is 0.
- R2: While chip select is low, dout_oe_o is high and dout_o carries a zero before the first rising serial clock edge. This holds whether the clock idles low, so the first edge is rising, or idles high, so the first edge is falling.
- R3: sample_o pulses for one system clock on the second rising serial clock edge of a frame. track_o is high from the start of the frame until that edge and low after it.
- R4: The first eight rising edges shift din_i into the control register, first bit as ctrl_o[7]. ctrl_o takes the new byte after the eighth edge. The field layout is ctrl_o[4:2] = channel and ctrl_o[1:0] = power mode.
- R5: The output word is 4 zeros then conv_data_i[11] down to conv_data_i[0]. conv_data_i is captured at the sample strobe. Bit k changes on the falling edge after rising edge k and is valid at rising edge k+1.
- R6: Raising chip select drops dout_oe_o and abandons the frame.
- R7: With chip select held low, rising edge 17 starts a new frame. That frame has its strobe on rising edge 18 and its leading zeros again.
- R8: sample_o is accompanied by a channel on sample_chan_o. That channel is the one written by the most recently completed sixteen-edge frame, or 0 if no frame has completed.
- R9: A frame cut short before its eighth rising edge leaves ctrl_o unchanged. A frame cut short before its sixteenth rising edge leaves the next frame's channel unchanged.
- R10: conv_done_o pulses once on the falling edge after the sixteenth rising edge, and not in an aborted frame.
- R11: If power mode is 2'b01 when a frame starts, wake_o pulses once, on the first falling serial clock edge of that frame. For any other mode, wake_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select from host, active low |
| sclk_i | input | 1 | Serial clock from host |
| din_i | input | 1 | Serial control data from host |
| conv_data_i | input | 12 | Conversion result from converter core |
| dout_o | output | 1 | Serial output data |
| dout_oe_o | output | 1 | Output enable for dout_o (low = high impedance) |
| track_o | output | 1 | Track/hold in track mode |
| sample_o | output | 1 | Hold-and-start-conversion strobe |
| sample_chan_o | output | 3 | Channel to convert at the strobe |
| conv_done_o | output | 1 | Conversion-complete pulse |
| wake_o | output | 1 | Wake-up request in autoshutdown mode |
| ctrl_o | output | 8 | Current control register |

## Verification
The assertions assume that the host's serial clock phases each last several system clock cycles, so that a rising edge and a falling edge never land in the same cycle after synchronisation. They also assume that din_i and chip select change only while the serial clock is steady. The bench drives every input on the falling system clock edge and holds each serial clock phase for six system clocks. It sets the clock's idle level before chip select falls, and it changes din_i only at the start of a low phase.

// File: rtl/adc_sr_pkg.sv
package adc_sr_pkg;
  typedef struct packed {
    logic       spare;
    logic       ref_ext;
    logic       zero_tag;
    logic [2:0] chan;
    logic [1:0] pm;
  } ctrl_t;

  localparam logic [1:0] PM_AUTO = 2'b01;
endpackage

// File: rtl/adc_sr_sync.sv
module adc_sr_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adc_sr_frame.sv
module adc_sr_frame #(
  parameter int FRAME_LEN   = 16,
  parameter int SAMPLE_EDGE = 2,
  parameter int CTRL_W      = 8,
  localparam int IDX_W      = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_s_i,
  input  logic             sclk_s_i,
  input  logic             pm_auto_i,
  output logic             active_o,
  output logic [IDX_W-1:0] out_idx_o,
  output logic             shift_en_o,
  output logic             wr_en_o,
  output logic             sample_o,
  output logic             frame_end_o,
  output logic             done_o,
  output logic             wake_o,
  output logic             track_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic             sclk_q, active_q, done_pend_q, fall_seen_q;
  logic [IDX_W-1:0] rise_cnt_q, out_idx_q;
  logic             rise, fall;

  assign rise = ~cs_s_i & sclk_s_i & ~sclk_q;
  assign fall = ~cs_s_i & ~sclk_s_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      rise_cnt_q  <= '0;
      out_idx_q   <= '0;
      done_pend_q <= 1'b0;
      fall_seen_q <= 1'b0;
    end else if (cs_s_i) begin
      active_q    <= 1'b0;
      rise_cnt_q  <= '0;
      out_idx_q   <= '0;
      done_pend_q <= 1'b0;
      fall_seen_q <= 1'b0;
    end else begin
      active_q <= 1'b1;
      if (rise) begin
        rise_cnt_q  <= (rise_cnt_q == LAST_IDX) ? '0 : rise_cnt_q + 1'b1;
        done_pend_q <= (rise_cnt_q == LAST_IDX);
      end
      if (fall) begin
        // bit index follows rising edges seen, so a leading fall keeps bit 0
        out_idx_q   <= rise_cnt_q;
        fall_seen_q <= 1'b1;
        done_pend_q <= 1'b0;
      end
    end
  end

  assign active_o    = active_q;
  assign out_idx_o   = out_idx_q;
  assign shift_en_o  = rise && (rise_cnt_q < IDX_W'(CTRL_W));
  assign wr_en_o     = rise && (rise_cnt_q == IDX_W'(CTRL_W - 1));
  assign sample_o    = rise && (rise_cnt_q == IDX_W'(SAMPLE_EDGE - 1));
  assign frame_end_o = rise && (rise_cnt_q == LAST_IDX);
  assign done_o      = fall && done_pend_q;
  assign wake_o      = fall && !fall_seen_q && pm_auto_i;
  assign track_o     = active_q && (rise_cnt_q < IDX_W'(SAMPLE_EDGE));

  p_sample_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
  p_track_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !track_o);
  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> !active_o);
  p_wake_once_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  p_done_after_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !done_o);
endmodule

// File: rtl/adc_sr_ctrl.sv
module adc_sr_ctrl
  import adc_sr_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       din_s_i,
  input  logic       shift_en_i,
  input  logic       wr_en_i,
  input  logic       frame_end_i,
  output ctrl_t      ctrl_o,
  output logic [2:0] chan_o
);
  logic [CTRL_W-1:0] shift_q;
  ctrl_t             ctrl_q;
  logic [2:0]        shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      ctrl_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (shift_en_i) shift_q <= {shift_q[CTRL_W-2:0], din_s_i};
      if (wr_en_i)    ctrl_q  <= ctrl_t'({shift_q[CTRL_W-2:0], din_s_i});
      if (frame_end_i) shadow_q <= ctrl_q.chan;
    end
  end

  assign ctrl_o = ctrl_q;
  assign chan_o = shadow_q;

  p_ctrl_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_q));
  p_shadow_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(shadow_q));
endmodule

// File: rtl/adc_sr_dout.sv
module adc_sr_dout #(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 4,
  localparam int FRAME_LEN = DATA_W + LEAD_ZEROS,
  localparam int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              active_i,
  input  logic [IDX_W-1:0]  out_idx_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              dout_o
);
  logic [DATA_W-1:0]    data_q;
  logic [FRAME_LEN-1:0] word;
  logic [IDX_W-1:0]     bit_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_q <= '0;
    else if (sample_i) data_q <= conv_data_i;
  end

  assign word    = {{LEAD_ZEROS{1'b0}}, data_q};
  assign bit_sel = IDX_W'(FRAME_LEN - 1) - out_idx_i;
  assign dout_o  = active_i & word[bit_sel];

  p_lead_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_idx_i < IDX_W'(LEAD_ZEROS)) |-> !dout_o);
  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(data_q));
endmodule

// File: rtl/adc_serial_responder.sv
module adc_serial_responder
  import adc_sr_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 4,
  parameter int SAMPLE_EDGE = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_W     = $bits(ctrl_t),
  localparam int FRAME_LEN  = DATA_W + LEAD_ZEROS,
  localparam int IDX_W      = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              track_o,
  output logic              sample_o,
  output logic [2:0]        sample_chan_o,
  output logic              conv_done_o,
  output logic              wake_o,
  output logic [7:0]        ctrl_o
);
  logic             cs_s, sclk_s, din_s;
  logic             active, shift_en, wr_en, frame_end;
  logic [IDX_W-1:0] out_idx;
  ctrl_t            ctrl_q;

  adc_sr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, din_i}),
    .q_o   ({cs_s, sclk_s, din_s})
  );

  adc_sr_frame #(.FRAME_LEN(FRAME_LEN), .SAMPLE_EDGE(SAMPLE_EDGE), .CTRL_W(CTRL_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (cs_s),
    .sclk_s_i   (sclk_s),
    .pm_auto_i  (ctrl_q.pm == PM_AUTO),
    .active_o   (active),
    .out_idx_o  (out_idx),
    .shift_en_o (shift_en),
    .wr_en_o    (wr_en),
    .sample_o   (sample_o),
    .frame_end_o(frame_end),
    .done_o     (conv_done_o),
    .wake_o     (wake_o),
    .track_o    (track_o)
  );

  adc_sr_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .din_s_i    (din_s),
    .shift_en_i (shift_en),
    .wr_en_i    (wr_en),
    .frame_end_i(frame_end),
    .ctrl_o     (ctrl_q),
    .chan_o     (sample_chan_o)
  );

  adc_sr_dout #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) u_dout (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample_o),
    .active_i   (active),
    .out_idx_i  (out_idx),
    .conv_data_i(conv_data_i),
    .dout_o     (dout_o)
  );

  assign dout_oe_o = active;
  assign ctrl_o    = ctrl_q;

  p_cs_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_s) |=> !dout_oe_o);
  p_strobe_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !cs_s);
endmodule

// File: tb/adc_serial_responder_bench.sv
module adc_serial_responder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [11:0] conv_data = '0;
  logic        dout, dout_oe, track, sample, conv_done, wake;
  logic [2:0]  sample_chan;
  logic [7:0]  ctrl;

  int n_chk = 0, n_fail = 0;
  int strobe_cnt = 0, done_cnt = 0, wake_cnt = 0;
  logic [2:0] chan_log [64];

  always #4 clk = ~clk;

  adc_serial_responder u_adc_serial_responder (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .conv_data_i(conv_data), .dout_o(dout), .dout_oe_o(dout_oe), .track_o(track),
    .sample_o(sample), .sample_chan_o(sample_chan), .conv_done_o(conv_done),
    .wake_o(wake), .ctrl_o(ctrl)
  );

  always @(posedge clk) if (rst_n) begin
    if (sample) begin
      chan_log[strobe_cnt & 63] <= sample_chan;
      strobe_cnt <= strobe_cnt + 1;
    end
    if (conv_done) done_cnt <= done_cnt + 1;
    if (wake) wake_cnt <= wake_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_word(input logic [11:0] d);
    logic [15:0] w;
    for (int p = 0; p < 16; p++) w[p] = (p < 4) ? 1'b0 : d[15-p];
    return w;
  endfunction

  // cap[i] is dout seen just before rising edge i+1
  task automatic frame(input logic [7:0] cbyte, input int n_rise, input bit idle_hi,
                       output logic [31:0] cap);
    cap = '0;
    sclk = idle_hi;
    tick(6);
    cs_n = 1'b0;
    tick(6);
    if (idle_hi) begin sclk = 1'b0; end
    for (int i = 0; i < n_rise; i++) begin
      din = ((i % 16) < 8) ? cbyte[7 - (i % 16)] : 1'b0;
      tick(6);
      cap[i] = dout;
      if (i == 0) chk("R2 oe before first edge", dout_oe, 1);
      if (i == 1) chk("R3 track before sample edge", track, 1);
      if (i == 2) chk("R3 track after sample edge", track, 0);
      sclk = 1'b1;
      tick(6);
      sclk = 1'b0;
    end
    tick(6);
    cs_n = 1'b1;
    tick(6);
    chk("R6 oe after cs high", dout_oe, 0);
  endtask

  task automatic run_all();
    logic [31:0] cap;
    int s0, d0, w0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    chk("R1 oe", dout_oe, 0);
    chk("R1 track", track, 0);
    chk("R1 ctrl", ctrl, 0);
    chk("R1 chan", sample_chan, 0);

    // F1: chan 5, mode 0, first edge rising
    s0 = strobe_cnt; d0 = done_cnt; w0 = wake_cnt;
    conv_data = 12'hA5C;
    frame(8'h14, 16, 1'b0, cap);
    chk("R5 word idle low", cap[15:0], exp_word(12'hA5C));
    chk("R4 ctrl write", ctrl, 8'h14);
    chk("R3 one strobe", strobe_cnt - s0, 1);
    chk("R8 chan from reset", chan_log[s0 & 63], 0);
    chk("R10 done", done_cnt - d0, 1);
    chk("R11 no wake mode 0", wake_cnt - w0, 0);

    // F2: chan 2, autoshutdown, first edge falling
    s0 = strobe_cnt; d0 = done_cnt; w0 = wake_cnt;
    conv_data = 12'hFFF;
    frame(8'h09, 16, 1'b1, cap);
    chk("R2 R5 word idle high", cap[15:0], exp_word(12'hFFF));
    chk("R8 chan from previous frame", chan_log[s0 & 63], 5);
    chk("R11 mode written this frame not yet active", wake_cnt - w0, 0);
    chk("R10 done", done_cnt - d0, 1);

    // F3: abort after 12 edges
    s0 = strobe_cnt; d0 = done_cnt; w0 = wake_cnt;
    frame(8'h1D, 12, 1'b1, cap);
    chk("R4 ctrl written before abort", ctrl, 8'h1D);
    chk("R10 no done on abort", done_cnt - d0, 0);
    chk("R11 wake in auto mode", wake_cnt - w0, 1);
    chk("R8 chan", chan_log[s0 & 63], 2);

    // F4: abort after 5 edges
    s0 = strobe_cnt; w0 = wake_cnt;
    frame(8'hFF, 5, 1'b0, cap);
    chk("R9 ctrl unchanged", ctrl, 8'h1D);
    chk("R9 chan after abort", chan_log[s0 & 63], 2);
    chk("R11 wake on later fall", wake_cnt - w0, 1);

    // F5: full frame, channel must still be the one from F2
    s0 = strobe_cnt; w0 = wake_cnt;
    conv_data = 12'h123;
    frame(8'h0C, 16, 1'b0, cap);
    chk("R9 channel unchanged by aborted frame", chan_log[s0 & 63], 2);
    chk("R5 word", cap[15:0], exp_word(12'h123));
    chk("R11 wake", wake_cnt - w0, 1);

    // F6: continuous, two frames under one chip select
    s0 = strobe_cnt; d0 = done_cnt; w0 = wake_cnt;
    conv_data = 12'h9B7;
    frame(8'h18, 32, 1'b0, cap);
    chk("R7 two strobes", strobe_cnt - s0, 2);
    chk("R7 first word", cap[15:0], exp_word(12'h9B7));
    chk("R7 second word", cap[31:16], exp_word(12'h9B7));
    chk("R8 chan first frame", chan_log[s0 & 63], 3);
    chk("R7 R8 chan second frame", chan_log[(s0 + 1) & 63], 6);
    chk("R10 two done", done_cnt - d0, 2);
    chk("R11 no wake mode 0", wake_cnt - w0, 0);

    // sweep: walking one and walking zero over the data, channel = k mod 8
    for (int k = 0; k < 24; k++) begin
      logic [11:0] d;
      logic [2:0]  prev;
      d = (k < 12) ? (12'h1 << k) : ~(12'h1 << (k - 12));
      prev = (k == 0) ? 3'd6 : 3'((k - 1) % 8);
      s0 = strobe_cnt;
      conv_data = d;
      frame({3'b000, 3'(k % 8), 2'b00}, 16, k[0], cap);
      chk("R5 sweep word", cap[15:0], exp_word(d));
      chk("R8 sweep chan", chan_log[s0 & 63], prev);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule